// File: doc/BRIEF.md
# Converter Result Smoothing Filter and Threshold Monitor

This block sits behind a two-unit analog-to-digital converter and post-processes each conversion result as it arrives. A result is a valid-qualified word with a unit bit, a channel number and a data field. Two slots are provided: slot 0 takes every result from the first unit and slot 1 every result from the second unit. A result whose channel number is outside the supported range is discarded before it reaches either slot.

Each slot holds a first-order recursive smoothing filter whose weight is picked by a three-bit code. The filter state carries six extra fraction bits so that slow drifts and small inputs are not lost to truncation. Each slot also has a threshold comparator that can be armed to flag results above the threshold or results below it. Comparator events and an external measurement-finished pulse set two sticky status bits. A two-bit mask decides which status bits drive the single interrupt line. All configuration arrives through a plain write-only register port.

Top module: `adcpp_top`

## Requirements
- R1: After reset, `out_valid`, `int_status` and `irq` are all zero, the mask is zero, and both slots are disabled with a zero threshold.
- R2: A result with `res_valid` high and an in-range channel is accepted by slot 0 when `res_unit` is 0 and by slot 1 when it is 1. The matching `out_valid` bit is high for exactly the next cycle, and `out_data` (slot i at bits [12*i+11:12*i]) is updated in that same cycle.
- R3: With the filter enabled and primed, the state S (data with 6 fraction bits) becomes S + floor((x*64 - S) / k), and the output is floor(S/64). Codes 0, 1, 2 and 3 select k = 2, 4, 8 and 16; code 4 selects k = 64, and codes 5 to 7 also select k = 64.
- R4: The first accepted result after the filter enable goes from off to on loads the state with x*64 and outputs x unchanged. While the filter is off, the output equals the raw result and the slot becomes unprimed.
- R5: A result with a channel number of 10 or more produces no `out_valid`, leaves the filter state unchanged and raises no monitor event.
- R6: An armed monitor flags an accepted result above its threshold in high mode, or below its threshold in low mode. A result equal to the threshold never flags.
- R7: `int_status` bit 0 is set by any slot's monitor flag, and bit 1 is set by a `meas_done` pulse. Both bits are sticky until a write of 1 to the matching bit at address 3. When a set and a clear occur in the same cycle, the set wins. Status changes are visible in the cycle after the event.
- R8: `irq` is high exactly when some status bit is set and its mask bit is set. The mask is written at address 2, bits [1:0] (bit 0 is monitor, bit 1 is done, 3 enables both).
- R9: Addresses 0 and 1 configure slots 0 and 1. Bits [11:0] hold the threshold, bit 12 arms the monitor, bit 13 selects high mode (1) or low mode (0), bit 14 enables the filter, and bits [17:15] hold the coefficient code. A write takes effect for results in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| res_valid | input | 1 | Conversion result valid |
| res_unit | input | 1 | Converter unit of the result (0 or 1) |
| res_chan | input | 4 | Channel number of the result |
| res_data | input | 12 | Conversion data |
| meas_done | input | 1 | Measurement-finished pulse |
| out_valid | output | 2 | Per-slot filtered result valid |
| out_data | output | 24 | Per-slot filtered result, slot i at [12*i+11:12*i] |
| int_status | output | 2 | Sticky status: bit 0 monitor, bit 1 done |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check the following on every cycle: the one-cycle valid pulse after an accepted result, direct loading on the first sample, pass-through when the filter is off, that an equal threshold never flags, that discarded channels produce no output, status stickiness with set priority, and a silent interrupt under a zero mask. Only the bench's scenarios can show the arithmetic of the recursive filter across all five weights, the fraction bits keeping small inputs, routing by unit, and the combined effect of configuration rewrites. For these, the bench compares every output with a behavioural model in every cycle.

// File: rtl/adcpp_pkg.sv
package adcpp_pkg;

    localparam int FRAC_W = 6;

    typedef struct packed {
        logic       filt_en;
        logic [2:0] coef;
        logic       mon_en;
        logic       mon_high;
    } slot_ctrl_t;

    function automatic logic [2:0] coef_shift(input logic [2:0] code);
        case (code)
            3'd0:    coef_shift = 3'd1;
            3'd1:    coef_shift = 3'd2;
            3'd2:    coef_shift = 3'd3;
            3'd3:    coef_shift = 3'd4;
            default: coef_shift = 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/adcpp_slot.sv
module adcpp_slot
    import adcpp_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_ctrl_t        ctrl,
    input  logic [DATA_W-1:0] thresh,
    input  logic              take,
    input  logic [DATA_W-1:0] x,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              mon_hit
);
    localparam int ST_W = DATA_W + FRAC_W;

    typedef struct packed {
        logic [ST_W-1:0]   st;
        logic              primed;
        logic              ov;
        logic [DATA_W-1:0] od;
    } slot_state_t;

    slot_state_t s_d, s_q;

    logic [ST_W-1:0]   x_ext;
    logic signed [ST_W+1:0] diff;
    logic signed [ST_W+1:0] sum;
    logic [ST_W-1:0]   st_next;

    always_comb begin
        x_ext   = {x, {FRAC_W{1'b0}}};
        diff    = $signed({2'b00, x_ext}) - $signed({2'b00, s_q.st});
        sum     = $signed({2'b00, s_q.st}) + (diff >>> coef_shift(ctrl.coef));
        st_next = sum[ST_W-1:0];

        s_d    = s_q;
        s_d.ov = take;
        if (!ctrl.filt_en) begin
            s_d.primed = 1'b0;
        end
        if (take) begin
            if (!ctrl.filt_en) begin
                s_d.od = x;
            end else if (!s_q.primed) begin
                s_d.st     = x_ext;
                s_d.primed = 1'b1;
                s_d.od     = x;
            end else begin
                s_d.st = st_next;
                s_d.od = st_next[ST_W-1:FRAC_W];
            end
        end

        mon_hit = take && ctrl.mon_en &&
                  (ctrl.mon_high ? (x > thresh) : (x < thresh));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.ov;
    assign out_data  = s_q.od;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid); // R2
    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ctrl.filt_en && !s_q.primed) |=> (out_data == $past(x))); // R4
    AST_PASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !ctrl.filt_en) |=> (out_data == $past(x))); // R4
    AST_OFF_UNPRIMED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.filt_en |=> !s_q.primed); // R4
    AST_EQUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (take && x == thresh) |-> !mon_hit); // R6

endmodule

// File: rtl/adcpp_irq.sv
module adcpp_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set,
    input  logic [1:0] clr,
    input  logic [1:0] mask,
    output logic [1:0] status,
    output logic       irq
);
    logic [1:0] stat_d, stat_q;

    always_comb begin
        stat_d = (stat_q & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status = stat_q;
    assign irq    = |(stat_q & mask);

    AST_STICKY_MON: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !clr[0]) |=> stat_q[0]); // R7
    AST_STICKY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[1] && !clr[1]) |=> stat_q[1]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set[1] |=> stat_q[1]); // R7
    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq); // R8

endmodule

// File: rtl/adcpp_top.sv
module adcpp_top
    import adcpp_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 4,
    parameter int NUM_CH = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [31:0]         wr_data,
    input  logic                res_valid,
    input  logic                res_unit,
    input  logic [CHAN_W-1:0]   res_chan,
    input  logic [DATA_W-1:0]   res_data,
    input  logic                meas_done,
    output logic [1:0]          out_valid,
    output logic [2*DATA_W-1:0] out_data,
    output logic [1:0]          int_status,
    output logic                irq
);
    localparam int NUM_SLOT = 2;
    localparam int B_MON_EN = DATA_W;
    localparam int B_HIGH   = DATA_W + 1;
    localparam int B_FILT   = DATA_W + 2;
    localparam int B_COEF   = DATA_W + 3;

    typedef struct packed {
        slot_ctrl_t [NUM_SLOT-1:0]             ctrl;
        logic [NUM_SLOT-1:0][DATA_W-1:0]       thr;
        logic [1:0]                            mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [1:0]          clr;
    logic                in_range;
    logic [NUM_SLOT-1:0] take;
    logic [NUM_SLOT-1:0] hit;

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (wr_en) begin
            case (wr_addr)
                2'd0, 2'd1: begin
                    cfg_d.thr[wr_addr[0]]           = wr_data[DATA_W-1:0];
                    cfg_d.ctrl[wr_addr[0]].mon_en   = wr_data[B_MON_EN];
                    cfg_d.ctrl[wr_addr[0]].mon_high = wr_data[B_HIGH];
                    cfg_d.ctrl[wr_addr[0]].filt_en  = wr_data[B_FILT];
                    cfg_d.ctrl[wr_addr[0]].coef     = wr_data[B_COEF+:3];
                end
                2'd2:    cfg_d.mask = wr_data[1:0];
                default: clr        = wr_data[1:0];
            endcase
        end
        in_range = (32'(res_chan) < NUM_CH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
        assign take[i] = res_valid && in_range && (res_unit == 1'(i));

        adcpp_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl      (cfg_q.ctrl[i]),
            .thresh    (cfg_q.thr[i]),
            .take      (take[i]),
            .x         (res_data),
            .out_valid (out_valid[i]),
            .out_data  (out_data[i*DATA_W +: DATA_W]),
            .mon_hit   (hit[i])
        );
    end

    adcpp_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    ({meas_done, |hit}),
        .clr    (clr),
        .mask   (cfg_q.mask),
        .status (int_status),
        .irq    (irq)
    );

    AST_IGNORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && 32'(res_chan) >= NUM_CH) |=> (out_valid == 2'b00)); // R5
    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid)); // R2

endmodule

// File: tb/adcpp_top_tb_top.sv
module adcpp_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        res_valid = 1'b0;
    logic        res_unit = 1'b0;
    logic [3:0]  res_chan = '0;
    logic [11:0] res_data = '0;
    logic        meas_done = 1'b0;
    logic [1:0]  out_valid;
    logic [23:0] out_data;
    logic [1:0]  int_status;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcpp_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .res_valid(res_valid), .res_unit(res_unit), .res_chan(res_chan), .res_data(res_data),
        .meas_done(meas_done), .out_valid(out_valid), .out_data(out_data),
        .int_status(int_status), .irq(irq)
    );

    // behavioural reference model
    bit     m_fen[2], m_men[2], m_mhi[2], m_prime[2];
    int     m_code[2], m_thr[2], m_st[2];
    bit     e_ov[2];
    int     e_od[2];
    int     m_stat, m_mask;

    function automatic int kshift(int code);
        if (code == 0) return 1;
        if (code == 1) return 2;
        if (code == 2) return 3;
        if (code == 3) return 4;
        return 6;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_fen[i] = 0; m_men[i] = 0; m_mhi[i] = 0; m_prime[i] = 0;
                m_code[i] = 0; m_thr[i] = 0; m_st[i] = 0; e_ov[i] = 0; e_od[i] = 0;
            end
            m_stat = 0; m_mask = 0;
        end else begin
            int setv, clrv, x;
            bit hitany;
            setv = 0; clrv = 0; hitany = 0;
            x = int'(res_data);
            for (int i = 0; i < 2; i++) begin
                bit tk;
                tk = res_valid && (res_chan < 10) && (int'(res_unit) == i);
                e_ov[i] = tk;
                if (tk) begin
                    if (m_men[i] && (m_mhi[i] ? (x > m_thr[i]) : (x < m_thr[i]))) hitany = 1;
                    if (!m_fen[i]) e_od[i] = x;
                    else if (!m_prime[i]) begin
                        m_st[i] = x * 64; m_prime[i] = 1; e_od[i] = x;
                    end else begin
                        m_st[i] = m_st[i] + ((x * 64 - m_st[i]) >>> kshift(m_code[i]));
                        e_od[i] = m_st[i] / 64;
                    end
                end
                if (!m_fen[i]) m_prime[i] = 0;
            end
            if (hitany) setv |= 1;
            if (meas_done) setv |= 2;
            if (wr_en) begin
                // R9 register layout
                if (wr_addr <= 2'd1) begin
                    m_thr[wr_addr]  = int'(wr_data[11:0]);
                    m_men[wr_addr]  = wr_data[12];
                    m_mhi[wr_addr]  = wr_data[13];
                    m_fen[wr_addr]  = wr_data[14];
                    m_code[wr_addr] = int'(wr_data[17:15]);
                end else if (wr_addr == 2'd2) m_mask = int'(wr_data[1:0]);
                else clrv = int'(wr_data[1:0]);
            end
            m_stat = (m_stat & ~clrv) | setv;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                chk("R2 R5 out_valid", int'(out_valid[i]), int'(e_ov[i]));
                if (e_ov[i]) chk("R3 R4 out_data", int'(out_data[i*12 +: 12]), e_od[i]);
            end
            chk("R6 R7 int_status", int'(int_status), m_stat);
            chk("R8 irq", int'(irq), ((m_stat & m_mask) != 0) ? 1 : 0);
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(int a, int d);
        wr_en = 1; wr_addr = 2'(a); wr_data = 32'(d);
        step();
        wr_en = 0;
    endtask

    task automatic smp(int u, int c, int d);
        res_valid = 1; res_unit = 1'(u); res_chan = 4'(c); res_data = 12'(d);
        step();
        res_valid = 0;
    endtask

    function automatic int cfgw(int thr, int men, int hi, int fen, int code);
        return thr | (men << 12) | (hi << 13) | (fen << 14) | (code << 15);
    endfunction

    task automatic rnd_burst(int n, int cmax);
        for (int j = 0; j < n; j++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            smp(int'(seed[20]), int'(seed[27:24]) % cmax, int'(seed[31:20]));
        end
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        // R1 reset state, checked while reset is still held
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 int_status", int'(int_status), 0);
        chk("R1 irq", int'(irq), 0);
        rst_n = 1;
        step();

        // R2 R4 filters off: raw pass-through, routing by unit
        smp(0, 3, 700); smp(1, 4, 12); smp(0, 9, 4095);
        // R5 out-of-range channels
        smp(0, 10, 5); smp(1, 15, 9); step();

        wr(2, 3); // R8 both enabled
        wr(0, cfgw(100, 1, 1, 1, 0));  // R3 k=2, high monitor
        wr(1, cfgw(50, 1, 0, 1, 4));   // R3 k=64, low monitor
        // R6 equality never flags
        smp(0, 1, 100); smp(1, 2, 50); step();
        smp(0, 1, 300); smp(1, 0, 2000); smp(0, 1, 0); smp(1, 0, 0);
        rnd_burst(60, 12);
        // R7 clear and simultaneous set
        wr(3, 3); step();
        meas_done = 1; wr(3, 2); meas_done = 0; step();
        wr(3, 3);
        wr(2, 1); meas_done = 1; step(); meas_done = 0; // R8 mask monitor only
        wr(2, 2); step(); wr(2, 0); step();
        // R3 each coefficient code, fractional state with small inputs
        for (int c = 0; c < 8; c++) begin
            wr(0, cfgw(2000, 1, 1, 1, c));
            wr(1, cfgw(10, 1, 0, 1, 7 - c));
            for (int j = 0; j < 20; j++) begin
                smp(0, 5, 3); smp(1, 6, 4000 - j);
            end
            rnd_burst(20, 16);
            // R4 disable then re-enable: next sample loads directly
            wr(0, cfgw(2000, 0, 1, 0, c));
            smp(0, 2, 77);
            wr(0, cfgw(2000, 0, 1, 1, c));
            smp(0, 2, 1234); smp(0, 2, 0);
            wr(3, 3);
        end
        wr(2, 3);
        rnd_burst(200, 16);
        step(); step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule